// File: doc/BRIEF.md
# Shadow-Committed Pulse-Width Modulator Channel

This block is one pulse-width-modulation channel clocked by a fixed reference clock. A small write port loads three settings: a control word, a 16-bit duty count and a 16-bit period count. The control word holds a prescale select, a polarity bit and an enable bit. A prescaler slows the tick counter by 1, 2, 4 or 8. Within each period, the output sits at its active level while the tick count is below the duty count.

Every write lands in a shadow copy first. Writing the period register arms a commit. The shadow copy then moves into the active settings only when the running period ends, or on the next clock if the channel is idle. The output therefore never shows a mix of old and new settings. Clearing the enable bit is honoured at the next period end even when no commit is armed. After that the output stays low. Software writes the control word, then the duty, then the period, and uses the period write as the commit strobe.

Top module: `pwm_shadow_chan`

## Requirements
- R1: Control bits [1:0] select the clocks per tick: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. A period of P ticks therefore lasts P times that many clocks.
- R2: With polarity clear, the output is high while the tick count (0 to period-1) is below the duty count. Over any whole number of periods, the high time is duty×divisor clocks per period.
- R3: A duty count at or above the period count gives a constant active level. A duty of zero gives a constant inactive level.
- R4: Control bit 2 set inverts the output while the channel runs, so the output is low during the duty portion.
- R5: Writes to the control word (address 0) or the duty count (address 1) leave the output pattern unchanged until the period register (address 2) is written.
- R6: After a period write, the shadow settings take effect at the end of the running period, or one clock later if the channel is idle. The new settings start from tick 0 of a fresh period.
- R7: `commitPending` goes high on the clock after a period write. It stays high until the shadow-to-active transfer, and only a period write raises it.
- R8: Control bit 3 is the enable. Clearing it without a period write stops the channel at the end of the running period. After that, `isRunning` is low and the output is held low.
- R9: An active period count of zero leaves the channel idle, with the output low and `isRunning` low, even when enabled.
- R10: Reset clears all shadow and active settings, drives the output low and leaves no commit pending. A later period write alone therefore does not enable the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 duty, 2 period |
| wrData | input | 16 | Write data |
| pwmOut | output | 1 | Modulated output |
| isRunning | output | 1 | Channel enabled with a nonzero active period |
| commitPending | output | 1 | Period written, transfer not yet done |

## Verification
The bench commits settings while the channel is running, starting at a known phase of a long period. It checks that the output stays low through the old period's tail and goes high on the first clock of the new period. A design that loaded at once would cut the old period short. One that loaded on every duty or control write would show a blended pattern in the shadow-only test. A disable without a period write must let the current period run out and then hold the output low; a design that dropped the output early, or ignored the disable until the next commit, fails. The edge cases duty zero, duty at or beyond the period, inverted polarity and period zero each have their own vector. After reset, a lone period write must not bring the channel back up.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 2;
  localparam int CTRL_W = PS_W + 2;
  localparam int POL_BIT = PS_W;
  localparam int EN_BIT  = PS_W + 1;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;

  typedef struct packed {
    logic load;
    logic dropEn;
  } pwmStrobes_t;
endpackage

// File: rtl/pwm_shadow_ctl.sv
module pwm_shadow_ctl
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              atBoundary,
  input  logic              actEnabled,
  output logic [CTRL_W-1:0] shCtrl,
  output logic [CNT_W-1:0]  shDuty,
  output logic [CNT_W-1:0]  shPeriod,
  output logic              pending,
  output pwmStrobes_t       strobes
);
  logic periodWrite;

  assign periodWrite = wrEn && (wrAddr == ADDR_PERIOD);

  always_comb begin
    strobes.load   = atBoundary && pending;
    strobes.dropEn = atBoundary && !pending && actEnabled && !shCtrl[EN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shCtrl   <= '0;
      shDuty   <= '0;
      shPeriod <= '0;
      pending  <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL:   shCtrl   <= wrData[CTRL_W-1:0];
          ADDR_DUTY:   shDuty   <= wrData[CNT_W-1:0];
          ADDR_PERIOD: shPeriod <= wrData[CNT_W-1:0];
          default: ;
        endcase
      end
      if (periodWrite)       pending <= 1'b1;
      else if (strobes.load) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_shadow_dp.sv
module pwm_shadow_dp
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobes_t       strobes,
  input  logic [CTRL_W-1:0] shCtrl,
  input  logic [CNT_W-1:0]  shDuty,
  input  logic [CNT_W-1:0]  shPeriod,
  output logic              atBoundary,
  output logic              actEnabled,
  output logic              running,
  output logic              pwmOut
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [PS_W-1:0]  actPresc;
  logic             actPol;
  logic [CNT_W-1:0] actDuty;
  logic [CNT_W-1:0] actPeriod;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastCount;
  logic             tick;
  logic             lastTick;

  assign running   = actEnabled && (actPeriod != '0);
  assign divMask   = ~({DIV_W{1'b1}} << actPresc);
  assign tick      = running && (divCnt == divMask);
  assign lastCount = actPeriod - CNT_W'(1);
  assign lastTick  = tick && (tickCnt == lastCount);
  assign atBoundary = !running || lastTick;
  assign pwmOut    = running && ((tickCnt < actDuty) ^ actPol);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPresc   <= '0;
      actPol     <= 1'b0;
      actEnabled <= 1'b0;
      actDuty    <= '0;
      actPeriod  <= '0;
      divCnt     <= '0;
      tickCnt    <= '0;
    end else if (strobes.load) begin
      actPresc   <= shCtrl[PS_W-1:0];
      actPol     <= shCtrl[POL_BIT];
      actEnabled <= shCtrl[EN_BIT];
      actDuty    <= shDuty;
      actPeriod  <= shPeriod;
      divCnt     <= '0;
      tickCnt    <= '0;
    end else if (strobes.dropEn) begin
      actEnabled <= 1'b0;
      divCnt     <= '0;
      tickCnt    <= '0;
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) tickCnt <= lastTick ? '0 : tickCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [15:0] wrData,
  output logic        pwmOut,
  output logic        isRunning,
  output logic        commitPending
);
  pwmStrobes_t       strobes;
  logic [CTRL_W-1:0] shCtrl;
  logic [CNT_W-1:0]  shDuty;
  logic [CNT_W-1:0]  shPeriod;
  logic              atBoundary;
  logic              actEnabled;

  pwm_shadow_ctl #(.DATA_W(16)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .atBoundary(atBoundary), .actEnabled(actEnabled),
    .shCtrl(shCtrl), .shDuty(shDuty), .shPeriod(shPeriod),
    .pending(commitPending), .strobes(strobes)
  );

  pwm_shadow_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .shCtrl(shCtrl), .shDuty(shDuty), .shPeriod(shPeriod),
    .atBoundary(atBoundary), .actEnabled(actEnabled),
    .running(isRunning), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       pwmOut,
  input logic       isRunning,
  input logic       commitPending,
  input logic       loadStb
);
  logic periodWr;
  logic [1:0] rstCycles;
  assign periodWr = wrEn && (wrAddr == 2'd2);

  always_ff @(posedge clk) begin
    if (rstN) rstCycles <= 2'd0;
    else if (rstCycles != 2'd3) rstCycles <= rstCycles + 2'd1;
  end

  always @(posedge clk) begin
    if (!rstN && rstCycles >= 2'd1)
      AST_RESET_QUIET: assert (!pwmOut && !isRunning && !commitPending); // R10
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !isRunning |-> !pwmOut); // R8

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
    periodWr |=> commitPending); // R7

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !periodWr) |=> !commitPending); // R6

  AST_PEND_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitPending) |-> $past(periodWr)); // R7

  AST_LOAD_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> commitPending); // R6
endmodule

bind pwm_shadow_chan pwm_shadow_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .pwmOut(pwmOut), .isRunning(isRunning), .commitPending(commitPending),
  .loadStb(strobes.load)
);

// File: tb/pwm_shadow_chan_tb.sv
module pwm_shadow_chan_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmOut, isRunning, commitPending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_shadow_chan dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .isRunning(isRunning), .commitPending(commitPending)
  );

  // {ctrl[3:0], duty[15:0], period[15:0]}; ctrl bit3 enable, bit2 polarity, [1:0] prescale
  localparam logic [35:0] VEC [10] = '{
    {4'b1000, 16'd3,  16'd10},  // R2 div1
    {4'b1001, 16'd5,  16'd7},   // R1 div2
    {4'b1010, 16'd1,  16'd3},   // R1 div4
    {4'b1011, 16'd2,  16'd5},   // R1 div8
    {4'b1100, 16'd3,  16'd10},  // R4 inverted
    {4'b1000, 16'd10, 16'd10},  // R3 duty == period
    {4'b1000, 16'd20, 16'd6},   // R3 duty > period
    {4'b1000, 16'd0,  16'd6},   // R3 duty zero
    {4'b1100, 16'd0,  16'd6},   // R3 R4 duty zero inverted
    {4'b1000, 16'd5,  16'd0}    // R9 period zero
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic commit(input logic [3:0] c, input logic [15:0] du, input logic [15:0] pe);
    wrReg(2'd0, {12'd0, c});
    wrReg(2'd1, du);
    wrReg(2'd2, pe);
    check("R7 pending after period write", int'(commitPending), 1);
  endtask

  task automatic waitLoad(output int cycles);
    cycles = 0;
    while (commitPending && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic measure(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
  endtask

  task automatic syncRise();
    logic prev;
    prev = pwmOut;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pwmOut && !prev) break;
      prev = pwmOut;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int highs, cyc, win, expHi, div, act;
    logic prev;
    logic [3:0] c;
    logic [15:0] du, pe;

    repeat (3) @(negedge clk);
    check("R10 reset out", int'(pwmOut), 0);
    check("R10 reset running", int'(isRunning), 0);
    check("R10 reset pending", int'(commitPending), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      {c, du, pe} = VEC[v];
      commit(c, du, pe);
      waitLoad(cyc);
      div = 1 << c[1:0];
      if (!c[3] || pe == 0) begin
        win = 64; expHi = 0;
      end else begin
        win = 4 * int'(pe) * div;
        act = 4 * ((du < pe) ? int'(du) : int'(pe)) * div;
        expHi = c[2] ? win - act : act;
      end
      measure(win, highs);
      check($sformatf("R2 R3 R4 R9 vector %0d highs", v), highs, expHi);
      check($sformatf("R9 vector %0d running", v), int'(isRunning),
            (c[3] && pe != 0) ? 1 : 0);
    end

    // R1: tick length, div4 period 5 duty 2
    commit(4'b1010, 16'd2, 16'd5);
    waitLoad(cyc);
    syncRise();
    cyc = 0;
    while (pwmOut && cyc < 100) begin @(negedge clk); cyc++; end
    check("R1 high run length div4", cyc, 8);
    while (!pwmOut && cyc < 100) begin @(negedge clk); cyc++; end
    check("R1 period length div4", cyc, 20);

    // R5: ctrl/duty writes without period write change nothing
    commit(4'b1000, 16'd3, 16'd10);
    waitLoad(cyc);
    wrReg(2'd0, 16'h000C);
    wrReg(2'd1, 16'd7);
    repeat (30) @(negedge clk);
    check("R5 no pending without period write", int'(commitPending), 0);
    measure(40, highs);
    check("R5 shadow held", highs, 12);

    // R6: commit mid-period waits for boundary
    commit(4'b1000, 16'd3, 16'd100);
    waitLoad(cyc);
    syncRise();
    wrReg(2'd0, 16'h0008);
    wrReg(2'd1, 16'd50);
    wrReg(2'd2, 16'd60);
    check("R7 pending held mid-period", int'(commitPending), 1);
    prev = pwmOut;
    cyc = 0;
    while (commitPending && cyc < 500) begin
      prev = pwmOut;
      @(negedge clk);
      cyc++;
    end
    check("R6 old tail low before switch", int'(prev), 0);
    check("R6 new period starts active", int'(pwmOut), 1);
    check("R6 switch within old period", int'(cyc <= 100 && cyc >= 90), 1);
    measure(240, highs);
    check("R6 new pattern", highs, 200);

    // R8: disable waits for period end
    commit(4'b1000, 16'd3, 16'd100);
    waitLoad(cyc);
    syncRise();
    wrReg(2'd0, 16'h0000);
    check("R8 still running mid-period", int'(isRunning), 1);
    cyc = 0;
    while (isRunning && cyc < 500) begin @(negedge clk); cyc++; end
    check("R8 stop at period end", int'(cyc >= 90 && cyc <= 100), 1);
    check("R8 pending untouched", int'(commitPending), 0);
    measure(300, highs);
    check("R8 output held low", highs, 0);
    check("R8 stays stopped", int'(isRunning), 0);

    // R10: reset mid-run clears shadows
    commit(4'b1000, 16'd5, 16'd10);
    waitLoad(cyc);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 mid-run reset out", int'(pwmOut), 0);
    check("R10 mid-run reset running", int'(isRunning), 0);
    rstN = 1'b1;
    wrReg(2'd2, 16'd10);
    waitLoad(cyc);
    measure(50, highs);
    check("R10 cleared enable after reset", highs, 0);
    check("R10 not running after reset", int'(isRunning), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule